// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel that sits beside a free-running timer count. It is used in one of two modes. In capture mode it watches an external input and, when a chosen edge arrives, stores the present count in its channel register and raises its event flag. In compare mode it watches the count and raises the event flag when the count equals the channel register.

The external input is asynchronous to the block. It first passes through a two-flop synchronizer and then through edge detection.

A capture is a single shot. Once a capture has happened, the channel disarms itself and keeps the stored value until software arms it again. The channel register can also be loaded by software, which is how a compare value is set.

The event flag is sticky until software clears it. An interrupt request follows the flag, gated by an interrupt enable.

Top module: `tmr_chan`

## Requirements
- R1: After reset the channel register reads 0, the event flag and the interrupt request are 0, and the channel is disarmed.
- R2: In capture mode, while armed, a selected edge on `sig_i` loads `cnt_i` into the channel register and sets the flag. If `sig_i` changes before clock edge k, the register and the flag show the result after edge k+2 and not before. The captured value is the `cnt_i` sampled at edge k+2.
- R3: `edge_sel_i` selects the trigger edge: 2'b00 rising, 2'b01 falling, 2'b10 either edge, 2'b11 treated as rising. Edges of the other polarity do not capture.
- R4: A capture disarms the channel. Later edges leave the register and the flag unchanged until `arm_i` is pulsed.
- R5: Edges that arrive while the channel is disarmed, including the period from reset up to the first `arm_i` pulse, have no effect.
- R6: In compare mode (`mode_i`=1), a cycle with `tick_i`=1 and `cnt_i` equal to the channel register sets the flag at the next clock edge. Compare mode never captures.
- R7: An equal count in a cycle with `tick_i`=0 does not set the flag.
- R8: The flag stays set until `clr_i` is asserted. When `clr_i` and a new event fall in the same cycle, the flag ends up set.
- R9: `irq_o` equals the flag ANDed with `ie_i`.
- R10: `ccr_we_i` loads `ccr_wd_i` into the channel register at the next edge. If a capture happens in the same cycle, the capture takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CNT_W | Timer count |
| tick_i | input | 1 | Count-tick strobe |
| sig_i | input | 1 | Asynchronous external capture input |
| mode_i | input | 1 | 0 capture, 1 compare |
| edge_sel_i | input | 2 | Capture edge select |
| arm_i | input | 1 | Pulse that arms capture |
| clr_i | input | 1 | Software clear of the event flag |
| ie_i | input | 1 | Interrupt enable |
| ccr_we_i | input | 1 | Software write strobe for the channel register |
| ccr_wd_i | input | CNT_W | Software write data |
| ccr_o | output | CNT_W | Channel register |
| flag_o | output | 1 | Sticky channel event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A capture is due three clock edges after `sig_i` changes: two edges pass through the synchronizer and the third edge loads the register. The bench therefore holds `cnt_i` steady across those three edges and samples the outputs one edge early as well as on time. Compare hits, flag clears and register writes are due one edge after the inputs are applied, and `irq_o` follows the flag in the same cycle. All inputs are driven on the falling edge, and every output is sampled on the falling edge after the rising edge where its result is due.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_RSVD = 2'b11
  } edge_sel_e;

  typedef enum logic {
    MODE_CAPTURE = 1'b0,
    MODE_COMPARE = 1'b1
  } chan_mode_e;
endpackage

// File: rtl/tmr_chan_insync.sv
module tmr_chan_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o,
  output logic fall_o
);
  localparam int MSB = STAGES - 1;

  logic [MSB:0] sync_q, sync_d;
  logic         prev_q, prev_d;

  // shift chain next state
  always_comb begin
    sync_d = {sync_q[MSB-1:0], din};
    prev_d = sync_q[MSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = sync_q[MSB] & ~prev_q;
  assign fall_o = ~sync_q[MSB] & prev_q;
endmodule

// File: rtl/tmr_chan_trig.sv
module tmr_chan_trig
  import tmr_chan_pkg::*;
(
  input  logic       rise_i,
  input  logic       fall_i,
  input  edge_sel_e  edge_sel_i,
  input  chan_mode_e mode_i,
  input  logic       armed_i,
  output logic       cap_o
);
  logic hit;

  always_comb begin
    unique case (edge_sel_i)
      EDGE_FALL: hit = fall_i;
      EDGE_BOTH: hit = rise_i | fall_i;
      default:   hit = rise_i;   // rising and the reserved code
    endcase
    cap_o = hit & armed_i & (mode_i == MODE_CAPTURE);
  end
endmodule

// File: rtl/tmr_chan_flag.sv
module tmr_chan_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  // a new event outranks a clear
  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SYNC_FLOP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  input  logic             sig_i,
  input  logic             mode_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             arm_i,
  input  logic             clr_i,
  input  logic             ie_i,
  input  logic             ccr_we_i,
  input  logic [CNT_W-1:0] ccr_wd_i,
  output logic [CNT_W-1:0] ccr_o,
  output logic             flag_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] CCR_RST = '0;

  chan_mode_e       mode;
  edge_sel_e        esel;
  logic             rise, fall;
  logic             cap_pulse;
  logic             cmp_hit;
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] ccr_q, ccr_d;

  assign mode = chan_mode_e'(mode_i);
  assign esel = edge_sel_e'(edge_sel_i);

  tmr_chan_insync #(.STAGES(SYNC_FLOP)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (sig_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  tmr_chan_trig u_trig (
    .rise_i     (rise),
    .fall_i     (fall),
    .edge_sel_i (esel),
    .mode_i     (mode),
    .armed_i    (armed_q),
    .cap_o      (cap_pulse)
  );

  // compare is judged only on tick cycles
  assign cmp_hit = (mode == MODE_COMPARE) & tick_i & (cnt_i == ccr_q);

  always_comb begin
    ccr_d   = ccr_q;
    armed_d = armed_q;
    if (ccr_we_i)  ccr_d = ccr_wd_i;
    if (cap_pulse) begin
      ccr_d   = cnt_i;
      armed_d = 1'b0;
    end
    if (arm_i)     armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_q   <= CCR_RST;
      armed_q <= 1'b0;
    end else begin
      ccr_q   <= ccr_d;
      armed_q <= armed_d;
    end
  end

  tmr_chan_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (cap_pulse | cmp_hit),
    .clr_i  (clr_i),
    .flag_o (flag_o)
  );

  assign ccr_o = ccr_q;
  assign irq_o = flag_o & ie_i;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_i,
  input logic             tick_i,
  input logic             mode_i,
  input logic             arm_i,
  input logic             clr_i,
  input logic             ie_i,
  input logic             ccr_we_i,
  input logic [CNT_W-1:0] ccr_wd_i,
  input logic [CNT_W-1:0] ccr_o,
  input logic             flag_o,
  input logic             irq_o,
  input logic             cap_pulse,
  input logic             armed_q
);
  // R2
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |=> (ccr_o == $past(cnt_i)) && flag_o);

  // R4
  cap_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse && !arm_i |=> !armed_q);

  // R6
  cmp_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i && tick_i && (cnt_i == ccr_o) |=> flag_o);

  // R7
  cmp_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i && !tick_i && !flag_o |=> !flag_o);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && !clr_i |=> flag_o);

  // R8
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse && clr_i |=> flag_o);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (flag_o && ie_i));

  // R10
  sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ccr_we_i && !cap_pulse |=> ccr_o == $past(ccr_wd_i));
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_i     (cnt_i),
  .tick_i    (tick_i),
  .mode_i    (mode_i),
  .arm_i     (arm_i),
  .clr_i     (clr_i),
  .ie_i      (ie_i),
  .ccr_we_i  (ccr_we_i),
  .ccr_wd_i  (ccr_wd_i),
  .ccr_o     (ccr_o),
  .flag_o    (flag_o),
  .irq_o     (irq_o),
  .cap_pulse (cap_pulse),
  .armed_q   (armed_q)
);

// File: tb/tmr_chan_tb.sv
module tmr_chan_tb;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] cnt_i;
  logic             tick_i, sig_i, mode_i, arm_i, clr_i, ie_i, ccr_we_i;
  logic [1:0]       edge_sel_i;
  logic [CNT_W-1:0] ccr_wd_i;
  logic [CNT_W-1:0] ccr_o;
  logic             flag_o, irq_o;

  int checks = 0;
  int errors = 0;
  logic early_flag;

  always #5 clk = ~clk;

  tmr_chan #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .tick_i(tick_i), .sig_i(sig_i),
    .mode_i(mode_i), .edge_sel_i(edge_sel_i), .arm_i(arm_i), .clr_i(clr_i),
    .ie_i(ie_i), .ccr_we_i(ccr_we_i), .ccr_wd_i(ccr_wd_i),
    .ccr_o(ccr_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  // compare-mode vectors: {tick, cnt, clr, expected flag}; channel register holds 16'h0040
  localparam logic [18:0] CMP_VEC [0:7] = '{
    {1'b1, 16'h003F, 1'b0, 1'b0},   // R6 no match
    {1'b0, 16'h0040, 1'b0, 1'b0},   // R7 match without tick
    {1'b1, 16'h0040, 1'b0, 1'b1},   // R6 match on tick
    {1'b0, 16'h0041, 1'b0, 1'b1},   // R8 sticky
    {1'b0, 16'h0041, 1'b1, 1'b0},   // R8 clear
    {1'b1, 16'h0040, 1'b1, 1'b1},   // R8 event beats clear
    {1'b0, 16'h0040, 1'b1, 1'b0},   // R8 clear again
    {1'b1, 16'h0041, 1'b0, 1'b0}    // R6 no match
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_arm();
    arm_i = 1'b1; step(); arm_i = 1'b0;
  endtask

  task automatic pulse_clr();
    clr_i = 1'b1; step(); clr_i = 1'b0;
  endtask

  // change sig_i and hold cnt_i for the three edges a capture needs
  task automatic sig_to(input logic lvl, input logic [CNT_W-1:0] val);
    sig_i = lvl;
    cnt_i = val;
    step();
    step();
    early_flag = flag_o;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_i = '0; tick_i = 1'b0; sig_i = 1'b0; mode_i = 1'b0;
    edge_sel_i = 2'b00; arm_i = 1'b0; clr_i = 1'b0; ie_i = 1'b0;
    ccr_we_i = 1'b0; ccr_wd_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    check("R1 ccr", 32'(ccr_o), 32'h0);
    check("R1 flag", 32'(flag_o), 32'h0);
    check("R1 irq", 32'(irq_o), 32'h0);

    // R5: disarmed since reset
    sig_to(1'b1, 16'h0011);
    sig_to(1'b0, 16'h0012);
    check("R5 ccr", 32'(ccr_o), 32'h0);
    check("R5 flag", 32'(flag_o), 32'h0);

    // R2/R3 rising capture
    pulse_arm();
    sig_to(1'b1, 16'h0022);
    check("R2 latency", 32'(early_flag), 32'h0);
    check("R2 ccr", 32'(ccr_o), 32'h0022);
    check("R2 flag", 32'(flag_o), 32'h1);
    check("R9 irq gated off", 32'(irq_o), 32'h0);

    // R4 disarmed after capture
    pulse_clr();
    sig_to(1'b0, 16'h002F);
    sig_to(1'b1, 16'h0033);
    check("R4 ccr", 32'(ccr_o), 32'h0022);
    check("R4 flag", 32'(flag_o), 32'h0);

    // R3 falling select
    edge_sel_i = 2'b01;
    pulse_arm();
    sig_to(1'b0, 16'h0044);
    check("R3 fall ccr", 32'(ccr_o), 32'h0044);
    check("R3 fall flag", 32'(flag_o), 32'h1);
    pulse_clr();
    pulse_arm();
    sig_to(1'b1, 16'h0055);
    check("R3 rise ignored ccr", 32'(ccr_o), 32'h0044);
    check("R3 rise ignored flag", 32'(flag_o), 32'h0);
    sig_to(1'b0, 16'h0066);
    check("R3 fall after ignore", 32'(ccr_o), 32'h0066);

    // R3 either edge
    pulse_clr();
    edge_sel_i = 2'b10;
    pulse_arm();
    sig_to(1'b1, 16'h0077);
    check("R3 both rise", 32'(ccr_o), 32'h0077);
    pulse_clr();
    pulse_arm();
    sig_to(1'b0, 16'h0088);
    check("R3 both fall", 32'(ccr_o), 32'h0088);
    check("R3 both flag", 32'(flag_o), 32'h1);

    // R3 reserved code acts as rising
    pulse_clr();
    edge_sel_i = 2'b11;
    pulse_arm();
    sig_to(1'b1, 16'h0099);
    check("R3 rsvd rise", 32'(ccr_o), 32'h0099);
    pulse_clr();
    pulse_arm();
    sig_to(1'b0, 16'h00AA);
    check("R3 rsvd fall ignored", 32'(ccr_o), 32'h0099);
    check("R3 rsvd fall flag", 32'(flag_o), 32'h0);

    // R10 capture beats a write in the same cycle
    edge_sel_i = 2'b00;
    ccr_we_i = 1'b1;
    ccr_wd_i = 16'h1234;
    sig_to(1'b1, 16'h00BB);
    ccr_we_i = 1'b0;
    check("R10 capture priority", 32'(ccr_o), 32'h00BB);

    // R10 plain write
    pulse_clr();
    ccr_we_i = 1'b1;
    ccr_wd_i = 16'h0040;
    step();
    ccr_we_i = 1'b0;
    check("R10 write", 32'(ccr_o), 32'h0040);

    // R6/R7/R8/R9 compare table
    mode_i = 1'b1;
    ie_i = 1'b1;
    cnt_i = '0;
    tick_i = 1'b0;
    step();
    check("R6 start flag", 32'(flag_o), 32'h0);
    for (int i = 0; i < 8; i++) begin
      tick_i = CMP_VEC[i][18];
      cnt_i  = CMP_VEC[i][17:2];
      clr_i  = CMP_VEC[i][1];
      step();
      check($sformatf("R6/R7/R8 vec %0d flag", i), 32'(flag_o), 32'(CMP_VEC[i][0]));
      check($sformatf("R9 vec %0d irq", i), 32'(irq_o), 32'(CMP_VEC[i][0]));
    end
    tick_i = 1'b0;
    clr_i = 1'b0;

    // R6 compare mode does not capture
    sig_to(1'b0, 16'h00CC);
    sig_to(1'b1, 16'h00DD);
    check("R6 no capture in compare", 32'(ccr_o), 32'h0040);

    // R1 reset again
    rst_n = 1'b0;
    step();
    check("R1 reset ccr", 32'(ccr_o), 32'h0);
    check("R1 reset flag", 32'(flag_o), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule